// File: doc/BRIEF.md
# Differential PSK Phase Mapper and I/Q Modulator

This block turns the low bits of a payload word into one constellation sample per symbol. A mapper turns the payload bits into a Gray-coded static phase word. A per-symbol rotating offset is added to it modulo 16, and the resulting 4-bit phase index picks a signed I/Q pair. Each index k stands for the angle (2k+1)·π/16, so no point lies on an axis. All sixteen points are built from four programmable magnitudes, using sign changes and an I/Q swap.

The active mode changes only on a sync pulse. A sync pulse also returns the rotating offset to zero. Three modes are supported: rotating QPSK, plain 8-PSK and rotating 8-PSK. Any other mode code silences the outputs. The magnitude registers are written through a small address/data port. A typical use is a transmit channel that strobes one symbol at a time into a later pulse-shaping stage.

Top module: `psk_phase_mod`

## Requirements
- R1: After reset, `i_out` and `q_out` are 0, the rotating offset is 0, the active mode is 3'b000, and magnitude slots 0..3 hold 0x7CE1, 0x69DE, 0x46BD, 0x18D7.
- R2: The active mode loads from `mode_sel` only in a cycle where `sync_pulse` is high. Changes on `mode_sel` at other times have no effect on the outputs.
- R3: In mode 3'b001 (rotating QPSK), payload bits [1:0] map to static phase as 00→0, 01→4, 11→8, 10→12. Payload bit 2 is ignored.
- R4: In modes 3'b101 and 3'b110, payload bits [2:0] map to static phase as 111→0, 011→2, 010→4, 000→6, 001→8, 101→10, 100→12, 110→14.
- R5: The phase index is (static phase + rotating offset) mod 16. After each symbol the offset advances by 2 in mode 3'b001 and by 3 in mode 3'b110. In mode 3'b101 it stays at 0.
- R6: A sync pulse clears the rotating offset. A strobe in the same cycle as the sync uses the new mode with offset 0, and the offset then becomes that mode's step.
- R7: With slot j = index[1:0], a = slot j and b = slot 3−j, quadrant index[3:2] gives 0: (a, b), 1: (−b, a), 2: (−a, −b), 3: (b, −a). Negation is 16-bit two's complement.
- R8: A strobe in any mode code other than 001, 101 or 110 drives I and Q to 0. The offset stays 0 in such a mode.
- R9: I and Q are registered. They take a new value at the clock edge that samples `sym_stb`, and hold in every cycle without a strobe.
- R10: A write with `mag_we` high loads `mag_wdata` into slot `mag_addr` (0..3 = cos π/16 … cos 7π/16) at that edge. A strobe in the same cycle still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_stb | input | 1 | One-cycle symbol strobe |
| payload | input | 3 | Payload bits for the current symbol |
| mode_sel | input | 3 | Requested mode, taken on sync |
| sync_pulse | input | 1 | Loads the mode and clears the rotating offset |
| mag_we | input | 1 | Magnitude write enable |
| mag_addr | input | 2 | Magnitude slot address |
| mag_wdata | input | MAG_W (16) | Magnitude write data |
| i_out | output | MAG_W (16) | In-phase sample, two's complement |
| q_out | output | MAG_W (16) | Quadrature sample, two's complement |

## Verification
The bench sweeps every payload code in every mode, and also runs all five unsupported mode codes.

- Rotating 8-PSK runs long enough for the offset to wrap several times and visit all sixteen indices. An adder that is not truncated to four bits, or a wrong step, would show up as points in the wrong quadrant.
- Strobes are sent with a sync in the same cycle, with a sync in the middle of a stream, and with a magnitude write in the same cycle. A design that applied the offset before clearing it, or that forwarded the new write data, would emit the wrong point.
- Changes on `mode_sel` without a sync, and QPSK payloads with bit 2 toggled, must leave the output sequence untouched.

// File: rtl/psk_mod_pkg.sv
`timescale 1ns/1ps
package psk_mod_pkg;
    localparam int PH_W    = 4;
    localparam int NUM_MAG = 4;
    localparam int SLOT_W  = $clog2(NUM_MAG);
    localparam int MODE_W  = 3;
    localparam int SYM_W   = 3;

    localparam logic [MODE_W-1:0] MODE_OFF      = 3'b000;
    localparam logic [MODE_W-1:0] MODE_QPSK_ROT = 3'b001;
    localparam logic [MODE_W-1:0] MODE_8PSK     = 3'b101;
    localparam logic [MODE_W-1:0] MODE_8PSK_ROT = 3'b110;

    function automatic logic mode_valid(input logic [MODE_W-1:0] m);
        return (m == MODE_QPSK_ROT) || (m == MODE_8PSK) || (m == MODE_8PSK_ROT);
    endfunction

    function automatic logic [PH_W-1:0] rot_step(input logic [MODE_W-1:0] m);
        case (m)
            MODE_QPSK_ROT: return 4'd2;
            MODE_8PSK_ROT: return 4'd3;
            default:       return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/psk_sym_mapper.sv
`timescale 1ns/1ps
module psk_sym_mapper
    import psk_mod_pkg::*;
(
    input  logic [SYM_W-1:0]  sym_bits,
    input  logic [MODE_W-1:0] mode_eff,
    output logic [PH_W-1:0]   static_ph
);
    logic [PH_W-1:0] qpsk_ph;
    logic [PH_W-1:0] psk8_ph;

    // Gray code: each step of 4 changes one payload bit
    always_comb begin
        case (sym_bits[1:0])
            2'b00:   qpsk_ph = 4'd0;
            2'b01:   qpsk_ph = 4'd4;
            2'b11:   qpsk_ph = 4'd8;
            default: qpsk_ph = 4'd12;
        endcase
    end

    always_comb begin
        case (sym_bits)
            3'b111:  psk8_ph = 4'd0;
            3'b011:  psk8_ph = 4'd2;
            3'b010:  psk8_ph = 4'd4;
            3'b000:  psk8_ph = 4'd6;
            3'b001:  psk8_ph = 4'd8;
            3'b101:  psk8_ph = 4'd10;
            3'b100:  psk8_ph = 4'd12;
            default: psk8_ph = 4'd14;
        endcase
    end

    assign static_ph = (mode_eff == MODE_QPSK_ROT) ? qpsk_ph : psk8_ph;
endmodule

// File: rtl/psk_rot_phase.sv
`timescale 1ns/1ps
module psk_rot_phase
    import psk_mod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_stb,
    input  logic              sync_pulse,
    input  logic [MODE_W-1:0] mode_eff,
    output logic [PH_W-1:0]   rph_q
);
    logic [PH_W-1:0] rph_d;
    logic [PH_W-1:0] step;
    logic [PH_W-1:0] base;

    always_comb begin
        step = rot_step(mode_eff);
        base = sync_pulse ? '0 : rph_q;
        if (sym_stb)
            rph_d = (step == '0) ? '0 : base + step;
        else if (sync_pulse)
            rph_d = '0;
        else
            rph_d = rph_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rph_q <= '0;
        else        rph_q <= rph_d;
    end

    assert_qpsk_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && !sync_pulse && mode_eff == MODE_QPSK_ROT) |=> rph_q == $past(rph_q) + 4'd2);

    assert_8psk_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && !sync_pulse && mode_eff == MODE_8PSK_ROT) |=> rph_q == $past(rph_q) + 4'd3);

    assert_static_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_pulse && rot_step(mode_eff) == '0) |-> rph_q == '0);

    assert_sync_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && !sym_stb) |=> rph_q == '0);
endmodule

// File: rtl/psk_mag_bank.sv
`timescale 1ns/1ps
module psk_mag_bank
    import psk_mod_pkg::*;
#(
    parameter int MAG_W = 16,
    parameter logic [NUM_MAG*MAG_W-1:0] MAG_RST = {16'h18D7, 16'h46BD, 16'h69DE, 16'h7CE1}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mag_we,
    input  logic [SLOT_W-1:0]        mag_addr,
    input  logic [MAG_W-1:0]         mag_wdata,
    output logic [NUM_MAG*MAG_W-1:0] mags
);
    for (genvar g = 0; g < NUM_MAG; g++) begin : g_slot
        logic [MAG_W-1:0] mag_d;
        logic [MAG_W-1:0] mag_q;

        always_comb begin
            mag_d = mag_q;
            if (mag_we && mag_addr == SLOT_W'(g))
                mag_d = mag_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) mag_q <= MAG_RST[g*MAG_W +: MAG_W];
            else        mag_q <= mag_d;
        end

        assign mags[g*MAG_W +: MAG_W] = mag_q;

        assert_slot_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (mag_we && mag_addr == SLOT_W'(g)) |=> mag_q == $past(mag_wdata));
    end
endmodule

// File: rtl/psk_iq_select.sv
`timescale 1ns/1ps
module psk_iq_select
    import psk_mod_pkg::*;
#(
    parameter int MAG_W = 16
) (
    input  logic [PH_W-1:0]          phase,
    input  logic [NUM_MAG*MAG_W-1:0] mags,
    output logic [MAG_W-1:0]         i_sel,
    output logic [MAG_W-1:0]         q_sel
);
    logic [MAG_W-1:0] tab [NUM_MAG];
    logic [MAG_W-1:0] a;
    logic [MAG_W-1:0] b;

    for (genvar g = 0; g < NUM_MAG; g++) begin : g_tab
        assign tab[g] = mags[g*MAG_W +: MAG_W];
    end

    // slot 3-j is the bitwise inverse of a 2-bit j
    assign a = tab[phase[1:0]];
    assign b = tab[~phase[1:0]];

    always_comb begin
        case (phase[3:2])
            2'd0: begin i_sel = a;      q_sel = b;      end
            2'd1: begin i_sel = -b;     q_sel = a;      end
            2'd2: begin i_sel = -a;     q_sel = -b;     end
            default: begin i_sel = b;   q_sel = -a;     end
        endcase
    end
endmodule

// File: rtl/psk_phase_mod.sv
`timescale 1ns/1ps
module psk_phase_mod
    import psk_mod_pkg::*;
#(
    parameter int MAG_W = 16,
    parameter logic [NUM_MAG*MAG_W-1:0] MAG_RST = {16'h18D7, 16'h46BD, 16'h69DE, 16'h7CE1}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_stb,
    input  logic [SYM_W-1:0]  payload,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              sync_pulse,
    input  logic              mag_we,
    input  logic [SLOT_W-1:0] mag_addr,
    input  logic [MAG_W-1:0]  mag_wdata,
    output logic [MAG_W-1:0]  i_out,
    output logic [MAG_W-1:0]  q_out
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [MAG_W-1:0]  i;
        logic [MAG_W-1:0]  q;
    } state_t;

    state_t st_d, st_q;

    logic [MODE_W-1:0]        mode_eff;
    logic [PH_W-1:0]          rph_q;
    logic [PH_W-1:0]          rph_eff;
    logic [PH_W-1:0]          sph;
    logic [PH_W-1:0]          phase;
    logic [NUM_MAG*MAG_W-1:0] mags;
    logic [MAG_W-1:0]         i_sel;
    logic [MAG_W-1:0]         q_sel;

    assign mode_eff = sync_pulse ? mode_sel : st_q.mode;
    assign rph_eff  = sync_pulse ? '0 : rph_q;
    assign phase    = sph + rph_eff;

    psk_sym_mapper u_mapper (
        .sym_bits  (payload),
        .mode_eff  (mode_eff),
        .static_ph (sph)
    );

    psk_rot_phase u_rot (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_stb    (sym_stb),
        .sync_pulse (sync_pulse),
        .mode_eff   (mode_eff),
        .rph_q      (rph_q)
    );

    psk_mag_bank #(.MAG_W(MAG_W), .MAG_RST(MAG_RST)) u_mags (
        .clk       (clk),
        .rst_n     (rst_n),
        .mag_we    (mag_we),
        .mag_addr  (mag_addr),
        .mag_wdata (mag_wdata),
        .mags      (mags)
    );

    psk_iq_select #(.MAG_W(MAG_W)) u_iq (
        .phase (phase),
        .mags  (mags),
        .i_sel (i_sel),
        .q_sel (q_sel)
    );

    always_comb begin
        st_d = st_q;
        if (sync_pulse)
            st_d.mode = mode_sel;
        if (sym_stb) begin
            if (mode_valid(mode_eff)) begin
                st_d.i = i_sel;
                st_d.q = q_sel;
            end else begin
                st_d.i = '0;
                st_d.q = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_OFF;
            st_q.i    <= '0;
            st_q.q    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign i_out = st_q.i;
    assign q_out = st_q.q;

    assert_mode_only_on_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_pulse |=> $stable(st_q.mode));

    assert_qpsk_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == MODE_QPSK_ROT) |-> sph[1:0] == 2'b00);

    assert_8psk_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == MODE_8PSK || mode_eff == MODE_8PSK_ROT) |-> sph[0] == 1'b0);

    assert_unsupported_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && !mode_valid(mode_eff)) |=> (i_out == '0 && q_out == '0));

    assert_hold_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb |=> ($stable(i_out) && $stable(q_out)));
endmodule

// File: tb/psk_phase_mod_tb.sv
`timescale 1ns/1ps
module psk_phase_mod_tb;
    import psk_mod_pkg::*;

    localparam int MAG_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sym_stb = 1'b0;
    logic [SYM_W-1:0]  payload = '0;
    logic [MODE_W-1:0] mode_sel = '0;
    logic              sync_pulse = 1'b0;
    logic              mag_we = 1'b0;
    logic [SLOT_W-1:0] mag_addr = '0;
    logic [MAG_W-1:0]  mag_wdata = '0;
    logic [MAG_W-1:0]  i_out;
    logic [MAG_W-1:0]  q_out;

    always #2.5 clk = ~clk;

    psk_phase_mod u_dut (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .payload(payload),
        .mode_sel(mode_sel), .sync_pulse(sync_pulse), .mag_we(mag_we),
        .mag_addr(mag_addr), .mag_wdata(mag_wdata), .i_out(i_out), .q_out(q_out)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [MAG_W-1:0]  m_mag [NUM_MAG];
    logic [MODE_W-1:0] m_mode;
    logic [3:0]        m_rph;
    logic [MAG_W-1:0]  m_i, m_q;

    function automatic logic [3:0] ref_sph(input logic [2:0] md, input logic [2:0] p);
        if (md == 3'b001) begin
            case (p[1:0])
                2'b00: return 4'd0;
                2'b01: return 4'd4;
                2'b11: return 4'd8;
                default: return 4'd12;
            endcase
        end
        case (p)
            3'b111: return 4'd0;
            3'b011: return 4'd2;
            3'b010: return 4'd4;
            3'b000: return 4'd6;
            3'b001: return 4'd8;
            3'b101: return 4'd10;
            3'b100: return 4'd12;
            default: return 4'd14;
        endcase
    endfunction

    function automatic int ref_step(input logic [2:0] md);
        if (md == 3'b001) return 2;
        if (md == 3'b110) return 3;
        return 0;
    endfunction

    function automatic bit ref_ok(input logic [2:0] md);
        return md == 3'b001 || md == 3'b101 || md == 3'b110;
    endfunction

    task automatic model_sym(input logic [2:0] p);
        logic [3:0] ph;
        logic [MAG_W-1:0] a, b;
        if (!ref_ok(m_mode)) begin
            m_i = '0; m_q = '0;
        end else begin
            ph = 4'((int'(ref_sph(m_mode, p)) + int'(m_rph)) % 16);
            a = m_mag[ph[1:0]];
            b = m_mag[3 - int'(ph[1:0])];
            case (ph[3:2])
                2'd0: begin m_i = a;  m_q = b;  end
                2'd1: begin m_i = -b; m_q = a;  end
                2'd2: begin m_i = -a; m_q = -b; end
                default: begin m_i = b; m_q = -a; end
            endcase
        end
        m_rph = 4'((int'(m_rph) + ref_step(m_mode)) % 16);
    endtask

    task automatic check_iq(input string tag);
        checks++;
        if (i_out !== m_i || q_out !== m_q) begin
            fails++;
            $display("FAIL %s: I=%h Q=%h expected I=%h Q=%h", tag, i_out, q_out, m_i, m_q);
        end
    endtask

    task automatic sym(input logic [2:0] p, input string tag);
        sym_stb = 1'b1; payload = p;
        @(negedge clk);
        sym_stb = 1'b0;
        model_sym(p);
        check_iq(tag);
    endtask

    task automatic sync_to(input logic [2:0] md);
        mode_sel = md; sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        m_mode = md; m_rph = '0;
    endtask

    task automatic sync_sym(input logic [2:0] md, input logic [2:0] p, input string tag);
        mode_sel = md; sync_pulse = 1'b1; sym_stb = 1'b1; payload = p;
        @(negedge clk);
        sync_pulse = 1'b0; sym_stb = 1'b0;
        m_mode = md; m_rph = '0;
        model_sym(p);
        check_iq(tag);
    endtask

    task automatic wr_mag(input logic [1:0] a, input logic [MAG_W-1:0] v);
        mag_we = 1'b1; mag_addr = a; mag_wdata = v;
        @(negedge clk);
        mag_we = 1'b0;
        m_mag[a] = v;
    endtask

    task automatic wr_sym(input logic [1:0] a, input logic [MAG_W-1:0] v,
                          input logic [2:0] p, input string tag);
        mag_we = 1'b1; mag_addr = a; mag_wdata = v; sym_stb = 1'b1; payload = p;
        @(negedge clk);
        mag_we = 1'b0; sym_stb = 1'b0;
        model_sym(p);
        m_mag[a] = v;
        check_iq(tag);
    endtask

    task automatic idle(input int n, input string tag);
        repeat (n) @(negedge clk);
        check_iq(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_mag[0] = 16'h7CE1; m_mag[1] = 16'h69DE; m_mag[2] = 16'h46BD; m_mag[3] = 16'h18D7;
        m_mode = 3'b000; m_rph = '0; m_i = '0; m_q = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_iq("R1 reset outputs");
        sym(3'b000, "R1 reset mode is off");

        // R3 R5: rotating QPSK, bit 2 toggled
        sync_to(3'b001);
        for (int k = 0; k < 16; k++)
            sym(3'(k % 4) | ((k % 3 == 0) ? 3'b100 : 3'b000), "R3 R5 QPSK sweep");

        idle(3, "R9 hold without strobe");

        // R2: mode change without sync is ignored
        mode_sel = 3'b110;
        for (int k = 0; k < 6; k++)
            sym(3'(k), "R2 mode_sel ignored");
        mode_sel = 3'b000;
        sym(3'b011, "R2 mode_sel ignored");

        // R6: sync mid-stream clears offset
        sync_to(3'b001);
        sym(3'b001, "R6 sync clears offset");
        sym(3'b011, "R6 step after sync");

        // R4 R5: plain 8-PSK, all payloads twice
        sync_to(3'b101);
        for (int k = 0; k < 16; k++)
            sym(3'(k), "R4 R5 plain 8-PSK");

        // R4 R5 R7: rotating 8-PSK, offset wraps
        sync_to(3'b110);
        for (int k = 0; k < 40; k++)
            sym(3'((k * 5 + 1) % 8), "R4 R5 R7 rotating 8-PSK");

        // R6: sync and strobe in one cycle
        sync_sym(3'b001, 3'b010, "R6 sync with strobe");
        sym(3'b000, "R6 offset after sync strobe");
        sync_sym(3'b110, 3'b111, "R6 sync with strobe 8-PSK");
        sym(3'b111, "R6 offset after sync strobe 8-PSK");

        // R8: every unsupported code
        for (int c = 0; c < 8; c++) begin
            if (!ref_ok(3'(c))) begin
                sync_to(3'(c));
                sym(3'b101, "R8 unsupported zero");
                sym(3'b010, "R8 unsupported zero");
                sync_sym(3'(c), 3'b111, "R8 unsupported zero with sync");
            end
        end

        // R10 R7: new magnitudes, full index sweep
        wr_mag(2'd0, 16'h1234);
        wr_mag(2'd1, 16'h2345);
        wr_mag(2'd2, 16'h3456);
        wr_mag(2'd3, 16'h0101);
        sync_to(3'b110);
        for (int k = 0; k < 32; k++)
            sym(3'((k * 3) % 8), "R10 R7 written magnitudes");
        sync_to(3'b001);
        for (int k = 0; k < 8; k++)
            sym(3'(k), "R10 R7 QPSK written magnitudes");

        // R10: write and strobe together use the old value
        sync_to(3'b101);
        wr_sym(2'd3, 16'h7FFF, 3'b111, "R10 same-cycle write uses old");
        sym(3'b111, "R10 write visible next symbol");
        wr_mag(2'd0, 16'h8000);
        sym(3'b010, "R7 two's complement of 0x8000");
        sym(3'b001, "R7 two's complement of 0x8000");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule